// File: doc/BRIEF.md
# Mode-Dependent Special Function Register Access Firewall

This block sits between a CPU's special function register (SFR) bus and the peripherals behind it. It sorts every SFR address into one of five groups and decides, from the current CPU mode, whether a read or write may go through. Granted accesses are passed on as gated read and write strobes. Denied reads return zero, denied writes are dropped, and each denied access raises a violation flag for one cycle.

Two 8-bit permission registers are held inside the block. Together they form a 16-bit map with one bit per hardware-component SFR slot. In configuration mode, a hardware-component access is granted only when the bit for its slot is set. Only System-mode code may program the permission registers, and both reset to zero. Configuration-mode code therefore reaches no hardware component until System mode grants it. The peripherals themselves are outside the block. A small fixed address decode stands in for a full SFR map.

Top module: `sfr_firewall`

## Requirements
- R1: Address decode. 0x90–0x9D is system management. 0x9E is the low permission register (map bits 7:0). 0x9F is the high permission register (map bits 15:8). 0xA0–0xAF is hardware components, with slot = address bits 3:0. 0xF0–0xFF is test. Every other address is a general CPU register. Mode encoding: 0 = System, 1 = configuration, 2 = Test, 3 = Boot.
- R2: General CPU register accesses are granted in every mode.
- R3: Test-group accesses are granted only in Test mode.
- R4: System-management accesses are granted in System, Test and Boot modes, and denied in configuration mode.
- R5: Hardware-component accesses are granted in System, Test and Boot modes. In configuration mode they are granted exactly when map bit [slot] is set.
- R6: Writes to a permission register take effect at the next clock edge only in System mode. A write in any other mode leaves the map unchanged. Reads of the permission registers are granted in every mode and return the register value. Peripheral strobes never assert for these two addresses.
- R7: On a granted read of a peripheral SFR, the read data equals the peripheral data. On a denied read, the read data is zero and no peripheral strobe asserts. A denied write asserts no write strobe.
- R8: The violation output is high in the cycle after a cycle with a denied read or write, and low after a cycle with none.
- R9: After reset the permission map is all zeros and the violation output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current CPU mode |
| addr_i | input | 8 | SFR address |
| rd_i | input | 1 | Read strobe from CPU |
| wr_i | input | 1 | Write strobe from CPU |
| wdata_i | input | 8 | Write data (used for permission registers) |
| periph_rdata_i | input | 8 | Read data returned by peripherals |
| per_rd_o | output | 1 | Gated read strobe to peripherals |
| per_wr_o | output | 1 | Gated write strobe to peripherals |
| rdata_o | output | 8 | Filtered read data to CPU |
| fw_map_o | output | 16 | Permission map {high, low} |
| viol_o | output | 1 | Registered violation pulse |

## Verification
The only internal state is the permission map and the violation register, and both appear at the ports. A wrongly updated map is visible on `fw_map_o` right after the clock edge that wrote it. It also changes the grant for configuration-mode hardware-component accesses in that same cycle, so a wrong map shows on the strobes and read data of the next such access. Errors in the decode or the policy appear combinationally, on the strobes and read data of the access itself. A missing or extra violation shows one cycle later.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    typedef enum logic [1:0] {
        MODE_SYS  = 2'd0,
        MODE_CFG  = 2'd1,
        MODE_TEST = 2'd2,
        MODE_BOOT = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        GRP_CPU    = 3'd0,
        GRP_SYSMGT = 3'd1,
        GRP_FWCFG  = 3'd2,
        GRP_TEST   = 3'd3,
        GRP_HWC    = 3'd4
    } sfr_grp_e;

    localparam int unsigned SFR_AW = 8;

    localparam logic [SFR_AW-1:0] SYSMGT_LO = 8'h90;
    localparam logic [SFR_AW-1:0] SYSMGT_HI = 8'h9D;
    localparam logic [SFR_AW-1:0] FW_LO_ADR = 8'h9E;
    localparam logic [SFR_AW-1:0] FW_HI_ADR = 8'h9F;
    localparam logic [SFR_AW-1:0] HWC_BASE  = 8'hA0;
    localparam logic [SFR_AW-1:0] TEST_BASE = 8'hF0;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } grant_t;

endpackage

// File: rtl/sfw_decode.sv
module sfw_decode
    import sfw_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS  = 2 * DATA_W,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic [SFR_AW-1:0] addr_i,
    output sfr_grp_e          grp_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              fw_hi_o
);

    logic in_hwc;
    logic in_test;

    assign in_hwc  = (addr_i[SFR_AW-1:SLOT_W] == HWC_BASE[SFR_AW-1:SLOT_W]);
    assign in_test = (addr_i[SFR_AW-1:4] == TEST_BASE[SFR_AW-1:4]);
    assign slot_o  = addr_i[SLOT_W-1:0];
    assign fw_hi_o = (addr_i == FW_HI_ADR);

    always_comb begin
        if (addr_i == FW_LO_ADR || addr_i == FW_HI_ADR)
            grp_o = GRP_FWCFG;
        else if (addr_i >= SYSMGT_LO && addr_i <= SYSMGT_HI)
            grp_o = GRP_SYSMGT;
        else if (in_hwc)
            grp_o = GRP_HWC;
        else if (in_test)
            grp_o = GRP_TEST;
        else
            grp_o = GRP_CPU;
    end

endmodule

// File: rtl/sfw_policy.sv
module sfw_policy
    import sfw_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS  = 2 * DATA_W,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  cpu_mode_e         mode_i,
    input  sfr_grp_e          grp_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOTS-1:0]  fw_map_i,
    output grant_t            grant_o
);

    always_comb begin
        grant_o = '{rd_ok: 1'b0, wr_ok: 1'b0};
        unique case (grp_i)
            GRP_CPU: grant_o = '{rd_ok: 1'b1, wr_ok: 1'b1};
            GRP_SYSMGT: begin
                grant_o.rd_ok = (mode_i != MODE_CFG);
                grant_o.wr_ok = (mode_i != MODE_CFG);
            end
            GRP_FWCFG: begin
                grant_o.rd_ok = 1'b1;
                grant_o.wr_ok = (mode_i == MODE_SYS);
            end
            GRP_TEST: begin
                grant_o.rd_ok = (mode_i == MODE_TEST);
                grant_o.wr_ok = (mode_i == MODE_TEST);
            end
            GRP_HWC: begin
                grant_o.rd_ok = (mode_i != MODE_CFG) || fw_map_i[slot_i];
                grant_o.wr_ok = (mode_i != MODE_CFG) || fw_map_i[slot_i];
            end
            default: grant_o = '{rd_ok: 1'b0, wr_ok: 1'b0};
        endcase
    end

endmodule

// File: rtl/sfw_regs.sv
module sfw_regs #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_lo_i,
    input  logic              we_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SLOTS-1:0]  fw_map_o
);

    logic [DATA_W-1:0] half_q [2];
    logic [1:0]        we;

    assign we = {we_hi_i, we_lo_i};

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst)
                half_q[h] <= '0;
            else if (we[h])
                half_q[h] <= wdata_i;
        end
        assign fw_map_o[h*DATA_W +: DATA_W] = half_q[h];
    end

endmodule

// File: rtl/sfr_firewall.sv
module sfr_firewall
    import sfw_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS  = 2 * DATA_W,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [SFR_AW-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] periph_rdata_i,
    output logic              per_rd_o,
    output logic              per_wr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [SLOTS-1:0]  fw_map_o,
    output logic              viol_o
);

    cpu_mode_e         mode;
    sfr_grp_e          grp;
    logic [SLOT_W-1:0] slot;
    logic              fw_hi;
    logic              is_fw;
    grant_t            grant;
    logic              rd_pass;
    logic              wr_pass;
    logic              viol_q;
    logic [DATA_W-1:0] fw_rd;

    assign mode = cpu_mode_e'(mode_i);

    sfw_decode #(.DATA_W(DATA_W)) u_decode (
        .addr_i (addr_i),
        .grp_o  (grp),
        .slot_o (slot),
        .fw_hi_o(fw_hi)
    );

    sfw_policy #(.DATA_W(DATA_W)) u_policy (
        .mode_i  (mode),
        .grp_i   (grp),
        .slot_i  (slot),
        .fw_map_i(fw_map_o),
        .grant_o (grant)
    );

    assign is_fw   = (grp == GRP_FWCFG);
    assign rd_pass = rd_i & grant.rd_ok;
    assign wr_pass = wr_i & grant.wr_ok;

    sfw_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_lo_i (wr_pass & is_fw & ~fw_hi),
        .we_hi_i (wr_pass & is_fw & fw_hi),
        .wdata_i (wdata_i),
        .fw_map_o(fw_map_o)
    );

    assign fw_rd    = fw_hi ? fw_map_o[SLOTS-1:DATA_W] : fw_map_o[DATA_W-1:0];
    assign per_rd_o = rd_pass & ~is_fw;
    assign per_wr_o = wr_pass & ~is_fw;
    assign rdata_o  = !rd_pass ? '0 : (is_fw ? fw_rd : periph_rdata_i);

    always_ff @(posedge clk) begin
        if (rst)
            viol_q <= 1'b0;
        else
            viol_q <= (rd_i & ~grant.rd_ok) | (wr_i & ~grant.wr_ok);
    end
    assign viol_o = viol_q;

    AST_TEST_ONLY_IN_TEST: assert property (@(posedge clk) disable iff (rst)
        (grp == GRP_TEST && (per_rd_o || per_wr_o)) |-> (mode == MODE_TEST)); // R3

    AST_CFG_HWC_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CFG && grp == GRP_HWC && (per_rd_o || per_wr_o)) |-> fw_map_o[slot]); // R5

    AST_MAP_HELD: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && is_fw && mode == MODE_SYS) |=> $stable(fw_map_o)); // R6

    AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !grant.rd_ok) |-> (rdata_o == '0 && !per_rd_o)); // R7

    AST_VIOL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((rd_i && !per_rd_o && !is_fw) || (wr_i && !per_wr_o && !is_fw)) |=> viol_o); // R8

endmodule

// File: tb/sfr_firewall_bench.sv
module sfr_firewall_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'd0;
    logic [7:0]  addr_i = 8'h00;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  wdata_i = 8'h00;
    logic [7:0]  periph_rdata_i = 8'h00;
    logic        per_rd_o;
    logic        per_wr_o;
    logic [7:0]  rdata_o;
    logic [15:0] fw_map_o;
    logic        viol_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_map = 16'h0;
    bit done = 0;

    always #4 clk = ~clk;

    sfr_firewall u_sfr_firewall (
        .clk(clk), .rst(rst), .mode_i(mode_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .periph_rdata_i(periph_rdata_i), .per_rd_o(per_rd_o),
        .per_wr_o(per_wr_o), .rdata_o(rdata_o), .fw_map_o(fw_map_o),
        .viol_o(viol_o)
    );

    function automatic bit is_fwreg(input logic [7:0] a);
        return (a == 8'h9E) || (a == 8'h9F);
    endfunction

    // Expected grant from R1..R5, R6 (mode 0 Sys, 1 Cfg, 2 Test, 3 Boot)
    function automatic bit exp_ok(input logic [1:0] m, input logic [7:0] a,
                                  input bit is_wr, input logic [15:0] map);
        if (is_fwreg(a))                return is_wr ? (m == 2'd0) : 1'b1;
        if (a >= 8'h90 && a <= 8'h9D)   return m != 2'd1;
        if (a >= 8'hA0 && a <= 8'hAF)   return (m != 2'd1) || map[a[3:0]];
        if (a >= 8'hF0)                 return m == 2'd2;
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] m, input logic [7:0] a, input bit rd,
                          input bit wr, input logic [7:0] wd, input logic [7:0] pd);
        bit ok_r, ok_w;
        logic [7:0] er;
        @(negedge clk);
        mode_i = m; addr_i = a; rd_i = rd; wr_i = wr; wdata_i = wd; periph_rdata_i = pd;
        #1;
        ok_r = exp_ok(m, a, 1'b0, model_map);
        ok_w = exp_ok(m, a, 1'b1, model_map);
        er = 8'h00;
        if (rd && ok_r)
            er = is_fwreg(a) ? (a[0] ? model_map[15:8] : model_map[7:0]) : pd;
        check("R7 rdata", rdata_o, er);
        check("R7/R6 per_rd", per_rd_o, rd && ok_r && !is_fwreg(a));
        check("R7/R6 per_wr", per_wr_o, wr && ok_w && !is_fwreg(a));
        if (wr && ok_w && is_fwreg(a)) begin
            if (a[0]) model_map[15:8] = wd; else model_map[7:0] = wd;
        end
        @(posedge clk); #1;
        check("R8 viol", viol_o, (rd && !ok_r) || (wr && !ok_w));
        check("R6 map", fw_map_o, model_map);
        rd_i = 0; wr_i = 0;
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 6)
            0: return 8'h90 + 8'($urandom_range(0, 13));
            1: return 8'h9E + 8'($urandom_range(0, 1));
            2, 3: return 8'hA0 + 8'($urandom_range(0, 15));
            4: return 8'hF0 + 8'($urandom_range(0, 15));
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        #1600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        check("R9 reset map", fw_map_o, 16'h0);
        check("R9 reset viol", viol_o, 1'b0);

        // R5: config mode denied with empty map
        access(2'd1, 8'hA3, 1, 0, 8'h00, 8'h5A);
        // R6: config write to permission register ignored
        access(2'd1, 8'h9E, 0, 1, 8'hFF, 8'h00);
        access(2'd1, 8'h9E, 1, 0, 8'h00, 8'h00);
        // R6: system grants slots 0,2 and 9
        access(2'd0, 8'h9E, 0, 1, 8'h05, 8'h00);
        access(2'd0, 8'h9F, 0, 1, 8'h02, 8'h00);
        // R5: granted / denied slots in config mode
        access(2'd1, 8'hA0, 1, 0, 8'h00, 8'h3C);
        access(2'd1, 8'hA1, 0, 1, 8'h11, 8'h00);
        access(2'd1, 8'hA9, 0, 1, 8'h22, 8'h00);
        access(2'd1, 8'hAF, 1, 0, 8'h00, 8'h77);
        // R3: test group from system and test
        access(2'd0, 8'hF3, 0, 1, 8'h01, 8'h00);
        access(2'd2, 8'hF3, 1, 0, 8'h00, 8'hC3);
        // R4: sysmgmt in config vs boot
        access(2'd1, 8'h95, 1, 0, 8'h00, 8'h44);
        access(2'd3, 8'h9D, 1, 0, 8'h00, 8'h44);
        // R2: CPU general in every mode
        for (int m = 0; m < 4; m++) access(2'(m), 8'h81, 1, 0, 8'h00, 8'hE1);
        // R6: test/boot writes to permission register ignored, read back
        access(2'd2, 8'h9F, 0, 1, 8'hAA, 8'h00);
        access(2'd3, 8'h9F, 1, 0, 8'h00, 8'h00);

        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            bit w = r[8];
            access(2'(r[10:9]), pick_addr(r), !w, w, 8'($urandom), 8'($urandom));
        end

        // R9: reset clears map again
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        rst = 0; model_map = 16'h0;
        check("R9 reset map again", fw_map_o, 16'h0);
        check("R9 reset viol again", viol_o, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule